// File: doc/BRIEF.md
# GPIO Port with Change Interrupt

An eight-pin general-purpose I/O port for a small controller. Each pin has a direction bit and an output latch bit. The port also has weak pull-ups that one active-low control bit turns on as a group. Pin levels pass through a two-flop synchronizer and are then sampled once every instruction cycle of four clocks. A read of the port returns these sampled levels on every bit, whatever each bit's direction.

The four upper pins watch for a change. Whenever the port is read or written, a snapshot of the sampled levels is taken. Each upper pin that is configured as an input is compared with its snapshot bit, and any difference sets a sticky change flag. The flag cannot be cleared while that difference remains. Software must first read or write the port, which refreshes the snapshot, and then clear the flag. The flag, gated by an enable bit, drives an interrupt line and a wake request line.

Software reaches the port through a simple register bus. Write data is taken on the clock edge. Read data is combinational from the selected register.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset the direction bits are all 1 (every pin an input), the output latch is 0, the pull-up control reads 1 (pull-ups off), the change enable and the flag are 0, and a read of the control register (address 2) returns 0x80.
- R2: Register map: address 0 is the port, address 1 is direction, and address 2 is control. The control register holds bit 7 = pull-up disable (active low), bit 3 = change-interrupt enable, and bit 0 = flag. For each pin, pad_oe is 1 exactly when its direction bit is 0, and pad_out carries the output latch written at address 0.
- R3: pad_pu for a pin is 1 only when control bit 7 is 0 and that pin's direction bit is 1. An output pin never has its pull-up on.
- R4: A read at address 0 returns the pin levels after a two-flop synchronizer and a sample taken once every 4 clocks, for every bit, never the output latch. Between samples the value read stays constant.
- R5: Only pins 7 to 4 take part in change detection. A change on pins 3 to 0, or on an upper pin whose direction bit is 0, leaves the flag at 0.
- R6: A difference between an upper input pin's sampled level and its snapshot sets the flag (control bit 0). irq and wake are both the flag ANDed with control bit 3.
- R7: Writing control with bit 0 = 0 clears the flag, and writing bit 0 = 1 has no effect on it. While a difference persists, the flag stays set despite clear requests.
- R8: When a clear request and a difference fall in the same cycle, the flag is 1 afterwards.
- R9: Both a port read and a port write copy the current sampled levels into the snapshot, which ends a pending difference so that a later clear takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_rd | input | 1 | Read strobe (with bus_sel) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of addressed register |
| pin_i | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Output latch value to the pads |
| pad_oe | output | 8 | Per-pin output enable |
| pad_pu | output | 8 | Per-pin weak pull-up enable |
| irq | output | 1 | Change interrupt |
| wake | output | 1 | Wake request |

## Verification
The flag set caused by a live difference and the flag clear written over the bus can land on the same clock edge. The bench provokes this by toggling an upper input pin and then issuing the clear at a sweep of delays. The sweep covers the edge where the new sample first differs from the snapshot. In every case the interrupt must read 1 once the sample has settled, and an assertion checks that the clear-plus-difference cycle always leaves the flag set.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
    typedef enum logic [1:0] {
        ADR_PORT = 2'd0,
        ADR_DIR  = 2'd1,
        ADR_CTRL = 2'd2
    } gpio_addr_e;

    localparam int CTRL_PUN_BIT  = 7;
    localparam int CTRL_IE_BIT   = 3;
    localparam int CTRL_FLAG_BIT = 0;
endpackage

// File: rtl/gpio_sampler.sv
module gpio_sampler #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int TCY         = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] samp_o,
    output logic             tick_o
);
    localparam int CW = (TCY > 1) ? $clog2(TCY) : 1;
    localparam logic [CW-1:0] LAST = CW'(TCY - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0][WIDTH-1:0] sync;
        logic [CW-1:0]                     cnt;
        logic [WIDTH-1:0]                  samp;
    } smp_state_t;

    smp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sync[0] = pin_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + CW'(1);
        if (st_q.cnt == LAST) begin
            st_d.samp = st_q.sync[SYNC_STAGES-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign samp_o = st_q.samp;
    assign tick_o = (st_q.cnt == LAST);

    // R4: sampled value only moves on a sample tick
    a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_o |=> $stable(samp_o));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_chg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] lat_o,
    output logic [WIDTH-1:0] dir_o,
    output logic             pun_o,
    output logic             ie_o,
    output logic             port_rd_o,
    output logic             port_wr_o,
    output logic             clr_req_o
);
    typedef struct packed {
        logic [WIDTH-1:0] lat;
        logic [WIDTH-1:0] dir;
        logic             pun;
        logic             ie;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic wr_en, rd_en;

    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && bus_rd;

    always_comb begin
        st_d      = st_q;
        clr_req_o = 1'b0;
        port_wr_o = 1'b0;
        port_rd_o = rd_en && (bus_addr == ADR_PORT);
        if (wr_en) begin
            case (bus_addr)
                ADR_PORT: begin
                    st_d.lat  = bus_wdata;
                    port_wr_o = 1'b1;
                end
                ADR_DIR:  st_d.dir = bus_wdata;
                ADR_CTRL: begin
                    st_d.pun  = bus_wdata[CTRL_PUN_BIT];
                    st_d.ie   = bus_wdata[CTRL_IE_BIT];
                    clr_req_o = !bus_wdata[CTRL_FLAG_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lat <= '0;
            st_q.dir <= '1;
            st_q.pun <= 1'b1;
            st_q.ie  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lat_o = st_q.lat;
    assign dir_o = st_q.dir;
    assign pun_o = st_q.pun;
    assign ie_o  = st_q.ie;

    // R2: a direction write lands in the direction register
    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == ADR_DIR) |=> (dir_o == $past(bus_wdata)));
    // R2: a port write lands in the output latch
    a_r2_lat_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == ADR_PORT) |=> (lat_o == $past(bus_wdata)));
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
    parameter int WIDTH  = 8,
    parameter int CHG_LO = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] samp_i,
    input  logic [WIDTH-1:0] dir_i,
    input  logic             snap_load_i,
    input  logic             clr_req_i,
    output logic             flag_o
);
    localparam logic [WIDTH-1:0] CHG_MASK = {{(WIDTH-CHG_LO){1'b1}}, {CHG_LO{1'b0}}};

    typedef struct packed {
        logic [WIDTH-1:0] snap;
        logic             flag;
    } det_state_t;

    det_state_t st_d, st_q;
    logic [WIDTH-1:0] diff;
    logic             mismatch;

    always_comb begin
        st_d     = st_q;
        diff     = (samp_i ^ st_q.snap) & dir_i & CHG_MASK;
        mismatch = |diff;
        if (snap_load_i) st_d.snap = samp_i;
        if (mismatch)       st_d.flag = 1'b1;
        else if (clr_req_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // R6: a live difference sets the flag on the next edge
    a_r6_set_on_diff: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> flag_o);
    // R5: flag only rises after a qualified difference
    a_r5_rise_needs_diff: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(mismatch));
    // R7: flag is sticky without a clear request
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_req_i) |=> flag_o);
    // R8: set beats clear in the same cycle
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req_i && mismatch) |=> flag_o);
    // R9: port access refreshes the snapshot
    a_r9_snap_load: assert property (@(posedge clk) disable iff (!rst_n)
        snap_load_i |=> (st_q.snap == $past(samp_i)));
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
    import gpio_chg_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int CHG_LO      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int TCY         = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pu,
    output logic             irq,
    output logic             wake
);
    logic [WIDTH-1:0] samp, lat, dir;
    logic tick, pun, ie, port_rd, port_wr, clr_req, flag;

    gpio_sampler #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES), .TCY(TCY)) u_smp (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .samp_o(samp), .tick_o(tick)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .lat_o(lat), .dir_o(dir), .pun_o(pun), .ie_o(ie),
        .port_rd_o(port_rd), .port_wr_o(port_wr), .clr_req_o(clr_req)
    );

    gpio_chg_detect #(.WIDTH(WIDTH), .CHG_LO(CHG_LO)) u_det (
        .clk(clk), .rst_n(rst_n), .samp_i(samp), .dir_i(dir),
        .snap_load_i(port_rd || port_wr), .clr_req_i(clr_req), .flag_o(flag)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_PORT: bus_rdata = samp;
            ADR_DIR:  bus_rdata = dir;
            ADR_CTRL: begin
                bus_rdata[CTRL_PUN_BIT]  = pun;
                bus_rdata[CTRL_IE_BIT]   = ie;
                bus_rdata[CTRL_FLAG_BIT] = flag;
            end
            default: ;
        endcase
    end

    assign pad_out = lat;
    assign pad_oe  = ~dir;
    assign pad_pu  = dir & {WIDTH{~pun}};
    assign irq     = flag & ie;
    assign wake    = flag & ie;

    // R3: disabling pull-ups by control write turns every pad pull-up off next cycle
    a_r3_pu_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADR_CTRL && bus_wdata[CTRL_PUN_BIT])
        |=> (pad_pu == '0));
    // R6: enable cleared by write silences irq next cycle
    a_r6_ie_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADR_CTRL && !bus_wdata[CTRL_IE_BIT])
        |=> (!irq && !wake));
endmodule

// File: tb/gpio_chg_port_test.sv
module gpio_chg_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;
    localparam int SETTLE     = 12;
    localparam int NVEC       = 6;
    // {dir, latch, pun(8b), exp_oe, exp_out, exp_pu}
    localparam logic [47:0] VEC [NVEC] = '{
        {8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF},
        {8'h00, 8'hA5, 8'h00, 8'hFF, 8'hA5, 8'h00},
        {8'h0F, 8'h3C, 8'h00, 8'hF0, 8'h3C, 8'h0F},
        {8'h0F, 8'h3C, 8'h01, 8'hF0, 8'h3C, 8'h00},
        {8'hF0, 8'h5A, 8'h00, 8'h0F, 8'h5A, 8'hF0},
        {8'h81, 8'hFF, 8'h01, 8'h7E, 8'hFF, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, pad_out, pad_oe, pad_pu;
    logic [7:0] pins = '0;
    logic irq, wake;
    int vectors = 0;
    int miscompares = 0;
    logic [7:0] rd_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_chg_port uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_i(pins), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu(pad_pu), .irq(irq), .wake(wake)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    // refresh snapshot and clear flag, IE on, pull-ups off
    task automatic rearm();
        logic [7:0] dummy;
        bus_read(2'd0, dummy);
        bus_write(2'd2, 8'h88);
        @(negedge clk);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_pu", pad_pu, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        bus_read(2'd2, rd_val);
        check("R1 ctrl", rd_val, 8'h80);
        bus_read(2'd1, rd_val);
        check("R1 dir", rd_val, 8'hFF);

        // R2/R3 vector table
        for (int i = 0; i < NVEC; i++) begin
            bus_write(2'd1, VEC[i][47:40]);
            bus_write(2'd0, VEC[i][39:32]);
            bus_write(2'd2, {VEC[i][24], 7'b000_0001});
            @(negedge clk);
            check("R2 pad_oe", pad_oe, VEC[i][23:16]);
            check("R2 pad_out", pad_out, VEC[i][15:8]);
            check("R3 pad_pu", pad_pu, VEC[i][7:0]);
        end

        // R4 port read returns pins, not latch
        bus_write(2'd1, 8'hFF);
        pins = 8'h96;
        settle();
        bus_read(2'd0, rd_val);
        check("R4 read inputs", rd_val, 8'h96);
        bus_write(2'd1, 8'h00);
        bus_write(2'd0, 8'h00);
        pins = 8'h5A;
        settle();
        bus_read(2'd0, rd_val);
        check("R4 read vs latch", rd_val, 8'h5A);

        // arm change detection with all inputs
        bus_write(2'd1, 8'hFF);
        rearm();
        settle();
        check("R7 clear after read", {7'b0, irq}, 8'h00);

        // R5 lower pins ignored
        pins = pins ^ 8'h0F;
        settle();
        check("R5 low pins", {7'b0, irq}, 8'h00);
        bus_read(2'd2, rd_val);
        check("R5 flag low pins", rd_val, 8'h88);
        // R5 output-configured upper pin ignored
        bus_write(2'd1, 8'hEF);
        pins = pins ^ 8'h10;
        settle();
        check("R5 output pin", {7'b0, irq}, 8'h00);
        rearm();
        bus_write(2'd1, 8'hFF);
        settle();
        check("R5 restore", {7'b0, irq}, 8'h00);

        // R6 upper input change sets flag
        pins = pins ^ 8'h40;
        settle();
        check("R6 irq", {7'b0, irq}, 8'h01);
        check("R6 wake", {7'b0, wake}, 8'h01);
        bus_write(2'd2, 8'h81);
        @(negedge clk);
        check("R6 irq gated", {7'b0, irq}, 8'h00);
        bus_read(2'd2, rd_val);
        check("R6 flag kept", rd_val, 8'h81);
        bus_write(2'd2, 8'h89);

        // R7 clear blocked while mismatch persists
        bus_write(2'd2, 8'h88);
        repeat (3) @(negedge clk);
        check("R7 clear blocked", {7'b0, irq}, 8'h01);
        bus_write(2'd2, 8'h89);
        rearm();
        check("R7 clear after read", {7'b0, irq}, 8'h00);

        // R9 port write refreshes snapshot
        pins = pins ^ 8'h80;
        settle();
        check("R9 irq before write", {7'b0, irq}, 8'h01);
        bus_write(2'd0, 8'h00);
        bus_write(2'd2, 8'h88);
        @(negedge clk);
        check("R9 clear after write", {7'b0, irq}, 8'h00);

        // R8 clear issued across the set edge: set wins
        for (int k = 0; k < 8; k++) begin
            rearm();
            pins = pins ^ 8'h20;
            repeat (k) @(negedge clk);
            bus_write(2'd2, 8'h88);
            settle();
            check("R8 set wins", {7'b0, irq}, 8'h01);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule